// File: doc/BRIEF.md
# Memory Target Burst Address Sequencer

This block produces the DWORD address of every data phase of a 32-bit memory-space burst seen by a target. During the address phase it stores the start address. It also stores the two low address bits, which encode the order in which the initiator wants the burst to proceed. The configured cacheline size is stored at the same moment. After that, each completed transfer moves the address forward in linear order or in cacheline-wrap order. A transfer is completed when the initiator-ready and target-ready inputs are both high on the same rising edge.

Some requested orders cannot be honoured: the two reserved codes, and a wrap request when no usable cacheline size is configured. For these the block raises a disconnect request during the first data phase. Exactly one transfer then completes, and the sequencer returns to idle. The final transfer of a normal burst is marked by the end-of-transaction input, and it also returns the block to idle.

The ready pair works as the handshake for the stream of addresses. `dw_addr` is the address of the data phase now pending. It is held for as many cycles as either side withholds its ready signal. It moves only on the edge where both ready signals are high. Nothing else creates back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `in_burst` and `disc_req` are 0.
- R2: An address-phase strobe while idle starts a burst. One cycle later `in_burst` is 1 and `dw_addr` equals `addr_in[31:2]`. `addr_in[1:0]` selects the order: 00 is linear, 10 is cacheline wrap, and 01 and 11 are reserved.
- R3: During a burst, `dw_addr` changes only after an edge on which `init_rdy` and `tgt_rdy` are both 1. In every other cycle it holds its value.
- R4: In linear order, each non-final transfer adds one to `dw_addr`, modulo 2^30.
- R5: In wrap order with a power-of-two line of L DWORDs, the offset inside the line goes up by one modulo L, and the line base stays the same.
- R6: In wrap order, once all L DWORDs of a line have been transferred, the next address is the start offset in the following line. For L=4 and start byte 08h, the byte addresses are 08h, 0Ch, 00h, 04h, 18h, 1Ch, 10h, 14h.
- R7: Order codes 01 and 11 make `disc_req` 1 during the first data phase. The burst ends after that single transfer.
- R8: Wrap order with a line size of 0 or a non-power-of-two line size also raises `disc_req` in the first phase and ends after one transfer. Linear order never requests a disconnect.
- R9: A transfer with `last_phase` high, or one with `disc_req` high, returns the block to idle. `dw_addr` then keeps the address of that final phase.
- R10: During a burst, the order and line size stored at the address phase stay fixed. A strobe or a change of `line_dw` inside a burst has no effect.
- R11: While idle, a ready handshake does not change `dw_addr`, and no burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strobe | input | 1 | Address phase indication |
| addr_in | input | 32 | Byte address; bits 1:0 carry the order code |
| init_rdy | input | 1 | Initiator ready |
| tgt_rdy | input | 1 | Target ready |
| line_dw | input | 8 | Cacheline size in DWORDs, 0 = none |
| last_phase | input | 1 | Current data phase is the final one |
| dw_addr | output | 30 | DWORD address of the pending data phase |
| in_burst | output | 1 | A burst is in progress |
| disc_req | output | 1 | Disconnect request for the current phase |

## Verification
The embedded properties check the following on every cycle:
- the address holds through wait cycles;
- each linear step adds exactly one;
- a wrap step inside a line keeps the line base;
- the stored order does not move during a burst;
- a disconnect or final transfer always lands in idle.

Some behaviour can only be shown by the bench's scenarios, because it needs a whole burst to unfold. This covers the full wrap sequence and the move to the next line for each line size and start offset. It also covers which codes and line sizes cause a disconnect, and the fact that strobes during a burst and handshakes while idle are ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_RSVD_A = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSVD_B = 2'b11
  } order_e;
endpackage

// File: rtl/burst_order_dec.sv
module burst_order_dec
  import burst_seq_pkg::*;
#(
  parameter int  LINE_W      = 8,
  parameter bit  WRAP_ENABLE = 1'b1
) (
  input  order_e              order,
  input  logic [LINE_W-1:0]   line_dw,
  output logic                wrap_en,
  output logic                single_only
);
  logic line_ok;

  always_comb begin
    line_ok = (line_dw != '0) && ((line_dw & (line_dw - 1'b1)) == '0);
  end

  generate
    if (WRAP_ENABLE) begin : g_wrap
      always_comb begin
        wrap_en     = (order == ORD_WRAP) && line_ok;
        single_only = (order == ORD_RSVD_A) || (order == ORD_RSVD_B) ||
                      ((order == ORD_WRAP) && !line_ok);
      end
    end else begin : g_nowrap
      always_comb begin
        wrap_en     = 1'b0;
        single_only = (order != ORD_LINEAR) && line_ok | (order != ORD_LINEAR);
      end
    end
  endgenerate
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr #(
  parameter int DW_W = 30
) (
  input  logic [DW_W-1:0] cur_dw,
  input  logic [DW_W-1:0] start_off,
  input  logic [DW_W-1:0] line_mask,
  input  logic [DW_W-1:0] line_len,
  input  logic            wrap_en,
  output logic [DW_W-1:0] next_dw
);
  logic [DW_W-1:0] inc, low_nxt, base;

  always_comb begin
    inc     = cur_dw + DW_W'(1);
    low_nxt = inc & line_mask;
    base    = cur_dw & ~line_mask;
    if (!wrap_en)
      next_dw = inc;
    else if (low_nxt == start_off)
      next_dw = base + line_len + start_off;
    else
      next_dw = base | low_nxt;
  end
endmodule

// File: rtl/burst_phase_ctl.sv
module burst_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_strobe,
  input  logic xfer,
  input  logic last_phase,
  input  logic single_only,
  output logic in_burst,
  output logic load,
  output logic advance,
  output logic disc_req
);
  logic first_q, ending;

  always_comb begin
    load     = !in_burst && addr_strobe;
    disc_req = in_burst && first_q && single_only;
    ending   = in_burst && xfer && (last_phase || disc_req);
    advance  = in_burst && xfer && !ending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
      first_q  <= 1'b0;
    end else if (load) begin
      in_burst <= 1'b1;
      first_q  <= 1'b1;
    end else if (ending) begin
      in_burst <= 1'b0;
      first_q  <= 1'b0;
    end else if (advance) begin
      first_q  <= 1'b0;
    end
  end

  // R7
  disc_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req && xfer |=> !in_burst);
  // R9
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && xfer && last_phase |=> !in_burst);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_W      = 8,
  parameter bit WRAP_ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              init_rdy,
  input  logic              tgt_rdy,
  input  logic [LINE_W-1:0] line_dw,
  input  logic              last_phase,
  output logic [ADDR_W-3:0] dw_addr,
  output logic              in_burst,
  output logic              disc_req
);
  localparam int DW_W = ADDR_W - 2;
  localparam int PAD  = DW_W - LINE_W;

  order_e             order_q;
  logic [LINE_W-1:0]  line_q;
  logic [DW_W-1:0]    dw_q, start_off_q, next_dw;
  logic [DW_W-1:0]    line_len, line_mask, in_mask;
  logic               xfer, load, advance, wrap_en, single_only;

  always_comb begin
    xfer      = init_rdy && tgt_rdy;
    line_len  = {{PAD{1'b0}}, line_q};
    line_mask = line_len - DW_W'(1);
    in_mask   = {{PAD{1'b0}}, line_dw} - DW_W'(1);
  end

  burst_order_dec #(.LINE_W(LINE_W), .WRAP_ENABLE(WRAP_ENABLE)) u_dec (
    .order(order_q), .line_dw(line_q),
    .wrap_en(wrap_en), .single_only(single_only)
  );

  burst_next_addr #(.DW_W(DW_W)) u_next (
    .cur_dw(dw_q), .start_off(start_off_q), .line_mask(line_mask),
    .line_len(line_len), .wrap_en(wrap_en), .next_dw(next_dw)
  );

  burst_phase_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .xfer(xfer),
    .last_phase(last_phase), .single_only(single_only),
    .in_burst(in_burst), .load(load), .advance(advance), .disc_req(disc_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dw_q        <= '0;
      order_q     <= ORD_LINEAR;
      line_q      <= '0;
      start_off_q <= '0;
    end else if (load) begin
      dw_q        <= addr_in[ADDR_W-1:2];
      order_q     <= order_e'(addr_in[1:0]);
      line_q      <= line_dw;
      start_off_q <= addr_in[ADDR_W-1:2] & in_mask;
    end else if (advance) begin
      dw_q        <= next_dw;
    end
  end

  assign dw_addr = dw_q;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && !xfer |=> $stable(dw_addr));
  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && order_q == ORD_LINEAR && xfer && !last_phase
    |=> dw_addr == $past(dw_addr) + DW_W'(1));
  // R5
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && wrap_en && xfer && !last_phase &&
    (((dw_addr + DW_W'(1)) & line_mask) != start_off_q)
    |=> (dw_addr & ~line_mask) == $past(dw_addr & ~line_mask));
  // R10
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && $past(in_burst) |-> order_q == $past(order_q) && line_q == $past(line_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_burst && !addr_strobe |=> !in_burst && $stable(dw_addr));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_strobe = 1'b0;
  logic [31:0] addr_in = '0;
  logic        init_rdy = 1'b0;
  logic        tgt_rdy = 1'b0;
  logic [7:0]  line_dw = '0;
  logic        last_phase = 1'b0;
  logic [29:0] dw_addr;
  logic        in_burst;
  logic        disc_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .addr_in(addr_in),
    .init_rdy(init_rdy), .tgt_rdy(tgt_rdy), .line_dw(line_dw),
    .last_phase(last_phase), .dw_addr(dw_addr), .in_burst(in_burst),
    .disc_req(disc_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] wrap_exp(input logic [29:0] s, input int l, input int n);
    logic [29:0] msk, base;
    int off;
    msk  = 30'(l - 1);
    base = s & ~msk;
    off  = int'(s & msk);
    return base + 30'((n / l) * l) + 30'((off + n % l) % l);
  endfunction

  task automatic open_burst(input logic [31:0] a, input logic [7:0] l);
    @(negedge clk);
    addr_strobe = 1'b1; addr_in = a; line_dw = l;
    @(negedge clk);
    addr_strobe = 1'b0;
    chk("R2", "in_burst after strobe", 32'(in_burst), 1);
    chk("R2", "start address", 32'(dw_addr), 32'(a[31:2]));
  endtask

  task automatic phase(input logic [29:0] exp, input bit last, input int waits,
                       input bit exp_disc, input string req);
    chk(req, "address", 32'(dw_addr), 32'(exp));
    chk(req, "disc_req", 32'(disc_req), 32'(exp_disc));
    for (int w = 0; w < waits; w++) begin
      init_rdy = w[0]; tgt_rdy = !w[0];
      @(negedge clk);
      chk("R3", "hold during wait", 32'(dw_addr), 32'(exp));
    end
    init_rdy = 1'b1; tgt_rdy = 1'b1; last_phase = last;
    @(negedge clk);
    init_rdy = 1'b0; tgt_rdy = 1'b0; last_phase = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [29:0] ex [8];
    ex = '{30'h2, 30'h3, 30'h0, 30'h1, 30'h6, 30'h7, 30'h4, 30'h5};
    repeat (3) @(negedge clk);
    chk("R1", "in_burst in reset", 32'(in_burst), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_burst after reset", 32'(in_burst), 0);
    chk("R1", "disc_req after reset", 32'(disc_req), 0);

    // R6: worked example, 16-byte line from 08h
    open_burst(32'h0000_000A, 8'd4);
    for (int n = 0; n < 8; n++) phase(ex[n], n == 7, n % 2, 1'b0, "R6");
    chk("R9", "idle after last", 32'(in_burst), 0);
    chk("R9", "address kept", 32'(dw_addr), 32'(ex[7]));

    // R11: handshake while idle
    init_rdy = 1'b1; tgt_rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    init_rdy = 1'b0; tgt_rdy = 1'b0;
    chk("R11", "idle address", 32'(dw_addr), 32'(ex[7]));
    chk("R11", "still idle", 32'(in_burst), 0);

    // R4: linear bursts, including wrap of the address space
    for (int k = 0; k < 3; k++) begin
      logic [29:0] s;
      s = (k == 0) ? 30'h400 : (k == 1) ? 30'h3FFF_FFFD : 30'h123;
      open_burst({s, 2'b00}, 8'd0);
      for (int n = 0; n < 6; n++) phase(s + 30'(n), n == 5, n % 3, 1'b0, "R4");
      chk("R9", "idle after linear", 32'(in_burst), 0);
    end

    // R5/R6: sweep line sizes and all start offsets
    for (int li = 0; li < 5; li++) begin
      int l;
      l = 1 << li;
      for (int off = 0; off < l; off++) begin
        logic [29:0] s;
        s = 30'h100 + 30'(off);
        open_burst({s, 2'b10}, 8'(l));
        for (int n = 0; n < 2 * l + 1; n++)
          phase(wrap_exp(s, l, n), n == 2 * l, (n % 3 == 1) ? 1 : 0, 1'b0,
                (n < l) ? "R5" : "R6");
        chk("R9", "idle after wrap", 32'(in_burst), 0);
      end
    end

    // R7: reserved codes
    for (int c = 0; c < 2; c++) begin
      open_burst({30'h200, (c == 0) ? 2'b01 : 2'b11}, 8'd4);
      phase(30'h200, 1'b0, 1, 1'b1, "R7");
      chk("R7", "idle after disconnect", 32'(in_burst), 0);
      chk("R9", "address kept after disconnect", 32'(dw_addr), 32'h200);
    end

    // R8: wrap with missing or odd line size; linear never disconnects
    open_burst({30'h300, 2'b10}, 8'd0);
    phase(30'h300, 1'b0, 0, 1'b1, "R8");
    chk("R8", "idle after line 0", 32'(in_burst), 0);
    open_burst({30'h301, 2'b10}, 8'd6);
    phase(30'h301, 1'b0, 2, 1'b1, "R8");
    chk("R8", "idle after line 6", 32'(in_burst), 0);
    open_burst({30'h302, 2'b00}, 8'd6);
    phase(30'h302, 1'b0, 0, 1'b0, "R8");
    phase(30'h303, 1'b1, 0, 1'b0, "R8");

    // R10: strobe and line size change mid-burst ignored
    open_burst({30'h105, 2'b10}, 8'd4);
    phase(wrap_exp(30'h105, 4, 0), 1'b0, 0, 1'b0, "R10");
    addr_strobe = 1'b1; addr_in = 32'h0000_5550; line_dw = 8'd8;
    @(negedge clk);
    addr_strobe = 1'b0;
    for (int n = 1; n < 6; n++)
      phase(wrap_exp(30'h105, 4, n), n == 5, 0, 1'b0, "R10");
    chk("R10", "idle after burst", 32'(in_burst), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule